// File: doc/BRIEF.md
# Gated Video Gain and Black-Level Servo

This block closes two slow control loops around an external video amplifier and converter. It watches each converted sample code and issues pump commands. One pair of commands charges or discharges the gain-control capacitor. The other pair charges or discharges the black-level (clamp) capacitor. A decoder supplies two strobes each line. The sync strobe covers the sync tip, and the gain loop uses it to pull the tip to code `SYNC_REF` (0). The porch strobe covers the back porch, and the clamp loop uses it to hold black at code `BLACK_REF` (64). Since sync spans 64 codes, a settled loop puts sync at 0 and black at 64. A peak-white limiter works in every mode and lowers gain whenever a sample reaches `PEAK_LIM` (248).

The block has two modes. After reset it runs in the coarse acquisition mode. In this mode a zero code seen outside the sync strobe is also treated as a clipped sync tip and lowers gain, so the signal is roughly spread between 0 and full scale. The block moves to the fine mode once strobes arrive distinctly, and it goes back to coarse when they stop.

Two state machines do this. The line tracker has the states WAIT_SYNC and WAIT_PORCH. A valid sync strobe moves it from WAIT_SYNC to WAIT_PORCH. A valid porch strobe in WAIT_PORCH completes a good line and returns it to WAIT_SYNC. When a window of `LINE_MAX` clocks passes without a good line, a missed line is counted and the tracker returns to WAIT_SYNC. The mode tracker has the states COARSE and FINE. It moves from COARSE to FINE on the `LOCK_LINES`-th consecutive good line. It moves from FINE to COARSE on the `LOSS_LINES`-th consecutive missed line. A strobe is valid only if it stayed high for at least `MIN_GATE` clocks (2 µs, which is 64 clocks at 32 MHz).

Top module: `vid_level_servo`

## Requirements
- R1: While `sync_gate` is high and the code is below 248, a code above 0 gives `gain_up` and a code of 0 gives `gain_dn`.
- R2: While `porch_gate` is high, a code above 64 gives `clamp_dn`, a code below 64 gives `clamp_up`, and a code of exactly 64 gives neither. While `porch_gate` is low, neither clamp output is asserted.
- R3: Any code of 248 or more gives `gain_dn` and no `gain_up`, in either mode and whatever the strobes are. This overrides R1.
- R4: In fine mode with `sync_gate` low, any code from 1 to 247 (which includes every nominal level up to 213) gives no gain request.
- R5: In coarse mode with `sync_gate` low, a code of 0 gives `gain_dn`.
- R6: Each output reflects the sample and strobes from the previous clock edge. `gain_up`/`gain_dn` are never high together, and neither are `clamp_up`/`clamp_dn`.
- R7: A strobe that is high for fewer than `MIN_GATE` consecutive clocks is ignored by the line tracker. A porch strobe with no valid sync strobe before it does not complete a line.
- R8: `fine_mode` (1 = fine, 0 = coarse) rises on the clock edge that sees the fall of the porch strobe completing the `LOCK_LINES`-th consecutive good line, and not before.
- R9: In fine mode, `LOSS_LINES` consecutive windows of `LINE_MAX` clocks with no good line return `fine_mode` to 0.
- R10: Synchronous active-high `rst` clears all four pump outputs and forces coarse mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| code | input | CODE_W | Converted sample code, straight binary |
| sync_gate | input | 1 | Strobe marking the sync tip |
| porch_gate | input | 1 | Strobe marking the back porch |
| gain_up | output | 1 | Charge command: raise amplifier gain |
| gain_dn | output | 1 | Discharge command: lower amplifier gain |
| clamp_up | output | 1 | Charge command: raise black level |
| clamp_dn | output | 1 | Discharge command: lower black level |
| fine_mode | output | 1 | 1 in fine mode, 0 in coarse acquisition |

## Verification
The hardest state to reach is fine mode with the strobes held in odd combinations. The exhaustive code sweeps keep a strobe high for hundreds of clocks, and this alone can complete or break lines. The bench therefore inserts one well-formed line before each sweep quarter, so the timeout window never runs out, and it resets before the lock test so stray lines from the coarse sweep leave no count behind. Loss of lock is checked just before and just after the third empty window. The timing is counted from the edge that completed the last good line.

// File: rtl/vll_pkg.sv
package vll_pkg;
    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_UP   = 2'd1,
        REQ_DOWN = 2'd2
    } req_t;

    typedef enum logic {
        MODE_COARSE = 1'b0,
        MODE_FINE   = 1'b1
    } mode_t;

    typedef enum logic {
        LN_WAIT_SYNC  = 1'b0,
        LN_WAIT_PORCH = 1'b1
    } line_t;
endpackage

// File: rtl/vll_gate_qual.sv
module vll_gate_qual #(
    parameter int MIN_W = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic gate,
    output logic valid_fall
);
    localparam int CW = $clog2(MIN_W + 1);

    logic [CW-1:0] hi_cnt;
    logic          gate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
            gate_q <= 1'b0;
        end else begin
            gate_q <= gate;
            if (!gate)
                hi_cnt <= '0;
            else if (hi_cnt != CW'(MIN_W))
                hi_cnt <= hi_cnt + CW'(1);
        end
    end

    // a strobe counts when it ends after at least MIN_W high samples
    assign valid_fall = gate_q && !gate && (hi_cnt == CW'(MIN_W));

    AST_VALID_NEEDS_FALL: assert property (@(posedge clk) disable iff (rst)
        valid_fall |-> (!gate && $past(gate))); // R7
endmodule

// File: rtl/vll_level_cmp.sv
module vll_level_cmp
    import vll_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int SYNC_REF  = 0,
    parameter int BLACK_REF = 64,
    parameter int PEAK_LIM  = 248
) (
    input  logic [CODE_W-1:0] code,
    input  logic              sync_gate,
    input  logic              porch_gate,
    input  logic              fine,
    output req_t              gain_req,
    output req_t              clamp_req
);
    localparam logic [CODE_W-1:0] SYNC_C  = CODE_W'(SYNC_REF);
    localparam logic [CODE_W-1:0] BLACK_C = CODE_W'(BLACK_REF);
    localparam logic [CODE_W-1:0] PEAK_C  = CODE_W'(PEAK_LIM);

    always_comb begin
        gain_req = REQ_NONE;
        if (code >= PEAK_C)
            gain_req = REQ_DOWN;                       // peak-white override
        else if (sync_gate)
            gain_req = (code > SYNC_C) ? REQ_UP : REQ_DOWN;
        else if (!fine && code <= SYNC_C)
            gain_req = REQ_DOWN;                       // coarse bottom clip
    end

    always_comb begin
        clamp_req = REQ_NONE;
        if (porch_gate) begin
            if (code > BLACK_C)
                clamp_req = REQ_DOWN;
            else if (code < BLACK_C)
                clamp_req = REQ_UP;
        end
    end
endmodule

// File: rtl/vll_mode_fsm.sv
module vll_mode_fsm
    import vll_pkg::*;
#(
    parameter int LOCK_LINES = 8,
    parameter int LOSS_LINES = 8,
    parameter int LINE_MAX   = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_ok,
    input  logic porch_ok,
    output logic fine
);
    localparam int TW  = $clog2(LINE_MAX);
    localparam int GCW = $clog2(LOCK_LINES + 1);
    localparam int MCW = $clog2(LOSS_LINES + 1);

    line_t          ln_q, ln_d;
    mode_t          mode_q, mode_d;
    logic [TW-1:0]  tmr;
    logic [GCW-1:0] good_cnt;
    logic [MCW-1:0] miss_cnt;
    logic           line_good, miss_evt;

    assign line_good = (ln_q == LN_WAIT_PORCH) && porch_ok;
    assign miss_evt  = (tmr == TW'(LINE_MAX - 1)) && !line_good;

    // state registers and line counters
    always_ff @(posedge clk) begin
        if (rst) begin
            ln_q     <= LN_WAIT_SYNC;
            mode_q   <= MODE_COARSE;
            tmr      <= '0;
            good_cnt <= '0;
            miss_cnt <= '0;
        end else begin
            ln_q   <= ln_d;
            mode_q <= mode_d;
            tmr    <= (line_good || miss_evt) ? '0 : tmr + TW'(1);
            if (line_good) begin
                miss_cnt <= '0;
                if (good_cnt != GCW'(LOCK_LINES))
                    good_cnt <= good_cnt + GCW'(1);
            end else if (miss_evt) begin
                good_cnt <= '0;
                if (miss_cnt != MCW'(LOSS_LINES))
                    miss_cnt <= miss_cnt + MCW'(1);
            end
        end
    end

    // line tracker transitions
    always_comb begin
        ln_d = ln_q;
        if (miss_evt)
            ln_d = LN_WAIT_SYNC;
        else begin
            unique case (ln_q)
                LN_WAIT_SYNC:  if (sync_ok)  ln_d = LN_WAIT_PORCH;
                LN_WAIT_PORCH: if (porch_ok) ln_d = LN_WAIT_SYNC;
            endcase
        end
    end

    // mode tracker transitions
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_COARSE: if (line_good && good_cnt >= GCW'(LOCK_LINES - 1))
                             mode_d = MODE_FINE;
            MODE_FINE:   if (miss_evt && miss_cnt >= MCW'(LOSS_LINES - 1))
                             mode_d = MODE_COARSE;
        endcase
    end

    assign fine = (mode_q == MODE_FINE);

    AST_LOCK_ON_PORCH: assert property (@(posedge clk) disable iff (rst)
        $rose(fine) |-> $past(porch_ok)); // R8
    AST_DROP_ON_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        ($fell(fine) && !$past(rst)) |-> ($past(tmr) == TW'(LINE_MAX - 1))); // R9
endmodule

// File: rtl/vid_level_servo.sv
module vid_level_servo
    import vll_pkg::*;
#(
    parameter int CODE_W     = 8,
    parameter int SYNC_REF   = 0,
    parameter int BLACK_REF  = 64,
    parameter int PEAK_LIM   = 248,
    parameter int MIN_GATE   = 64,
    parameter int LOCK_LINES = 8,
    parameter int LOSS_LINES = 8,
    parameter int LINE_MAX   = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    input  logic              sync_gate,
    input  logic              porch_gate,
    output logic              gain_up,
    output logic              gain_dn,
    output logic              clamp_up,
    output logic              clamp_dn,
    output logic              fine_mode
);
    localparam int NGATE = 2;
    localparam logic [CODE_W-1:0] PEAK_C = CODE_W'(PEAK_LIM);
    localparam logic [CODE_W-1:0] SYNC_C = CODE_W'(SYNC_REF);

    logic [NGATE-1:0] gate_v, ok_v;
    req_t             gain_req, clamp_req;

    assign gate_v = {porch_gate, sync_gate};

    for (genvar g = 0; g < NGATE; g++) begin : g_qual
        vll_gate_qual #(.MIN_W(MIN_GATE)) u_qual (
            .clk        (clk),
            .rst        (rst),
            .gate       (gate_v[g]),
            .valid_fall (ok_v[g])
        );
    end

    vll_mode_fsm #(
        .LOCK_LINES (LOCK_LINES),
        .LOSS_LINES (LOSS_LINES),
        .LINE_MAX   (LINE_MAX)
    ) u_mode (
        .clk      (clk),
        .rst      (rst),
        .sync_ok  (ok_v[0]),
        .porch_ok (ok_v[1]),
        .fine     (fine_mode)
    );

    vll_level_cmp #(
        .CODE_W    (CODE_W),
        .SYNC_REF  (SYNC_REF),
        .BLACK_REF (BLACK_REF),
        .PEAK_LIM  (PEAK_LIM)
    ) u_cmp (
        .code       (code),
        .sync_gate  (sync_gate),
        .porch_gate (porch_gate),
        .fine       (fine_mode),
        .gain_req   (gain_req),
        .clamp_req  (clamp_req)
    );

    // registered pump commands
    always_ff @(posedge clk) begin
        if (rst) begin
            gain_up  <= 1'b0;
            gain_dn  <= 1'b0;
            clamp_up <= 1'b0;
            clamp_dn <= 1'b0;
        end else begin
            gain_up  <= (gain_req  == REQ_UP);
            gain_dn  <= (gain_req  == REQ_DOWN);
            clamp_up <= (clamp_req == REQ_UP);
            clamp_dn <= (clamp_req == REQ_DOWN);
        end
    end

    AST_GAIN_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(gain_up && gain_dn)); // R6
    AST_CLAMP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(clamp_up && clamp_dn)); // R6
    AST_PEAK_WINS: assert property (@(posedge clk) disable iff (rst)
        (code >= PEAK_C) |=> (gain_dn && !gain_up)); // R3
    AST_PORCH_IDLE: assert property (@(posedge clk) disable iff (rst)
        !porch_gate |=> (!clamp_up && !clamp_dn)); // R2
    AST_FINE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (fine_mode && !sync_gate && code > SYNC_C && code < PEAK_C)
        |=> (!gain_up && !gain_dn)); // R4
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!gain_up && !gain_dn && !clamp_up && !clamp_dn && !fine_mode)); // R10
endmodule

// File: tb/vid_level_servo_tb.sv
module vid_level_servo_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W_GATE     = 4;
    localparam int N_LOCK     = 3;
    localparam int N_LOSS     = 3;
    localparam int WIN        = 1000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] code = '0;
    logic       sg = 1'b0, pg = 1'b0;
    logic       gain_up, gain_dn, clamp_up, clamp_dn, fine_mode;
    int         checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_level_servo #(
        .MIN_GATE(W_GATE), .LOCK_LINES(N_LOCK),
        .LOSS_LINES(N_LOSS), .LINE_MAX(WIN)
    ) u_dut (
        .clk(clk), .rst(rst), .code(code), .sync_gate(sg), .porch_gate(pg),
        .gain_up(gain_up), .gain_dn(gain_dn), .clamp_up(clamp_up),
        .clamp_dn(clamp_dn), .fine_mode(fine_mode)
    );

    wire [4:0] obs = {fine_mode, gain_up, gain_dn, clamp_up, clamp_dn};

    task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%b exp=%b (fine,gu,gd,cu,cd)", req, act, exp);
        end
    endtask

    // expected gain request {up,dn}
    function automatic logic [1:0] exp_gain(int c, bit ga, bit fine);
        if (c >= 248) return 2'b01;
        if (ga) return (c > 0) ? 2'b10 : 2'b01;
        if (!fine && c == 0) return 2'b01;
        return 2'b00;
    endfunction

    // expected clamp request {up,dn}
    function automatic logic [1:0] exp_clamp(int c, bit gb);
        if (!gb) return 2'b00;
        if (c > 64) return 2'b01;
        if (c < 64) return 2'b10;
        return 2'b00;
    endfunction

    function automatic string tag(int c, bit ga, bit fine);
        if (c >= 248) return "R3/R2";
        if (ga) return "R1/R2";
        if (fine) return "R4/R2";
        return "R5/R2";
    endfunction

    task automatic sweep(bit ga, bit gb, bit fine);
        sg = ga; pg = gb;
        for (int c = 0; c < 256; c++) begin
            code = 8'(c);
            @(negedge clk);
            chk(tag(c, ga, fine), obs, {fine, exp_gain(c, ga, fine), exp_clamp(c, gb)});
        end
        sg = 1'b0; pg = 1'b0;
    endtask

    task automatic line(int wa, int wb);
        sg = 1'b1; code = 8'd0;
        repeat (wa) @(negedge clk);
        sg = 1'b0;
        repeat (3) @(negedge clk);
        pg = 1'b1; code = 8'd64;
        repeat (wb) @(negedge clk);
        pg = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset;
        rst = 1'b1; sg = 1'b0; pg = 1'b0; code = 8'd100;
        repeat (2) @(negedge clk);
        chk("R10 reset", obs, 5'b00000);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // exhaustive coarse sweep over codes and strobe combinations
        sweep(0, 0, 0); sweep(1, 0, 0); sweep(0, 1, 0); sweep(1, 1, 0);

        // R6: one-cycle latency of a peak sample
        code = 8'd100; @(negedge clk);
        code = 8'd250;
        chk("R6 before edge", obs, 5'b00000);
        @(negedge clk);
        chk("R6 after edge", obs, 5'b00100);
        code = 8'd100; @(negedge clk);
        chk("R6 cleared", obs, 5'b00000);

        // R7: short strobes and porch-only lines never lock
        do_reset();
        repeat (N_LOCK + 1) line(W_GATE - 1, W_GATE - 1);
        chk("R7 short strobes", obs, 5'b00000);
        repeat (N_LOCK + 1) line(W_GATE - 1, W_GATE);
        chk("R7 short sync strobe", obs, 5'b00000);

        // R8: lock on exactly the N_LOCK-th good line
        do_reset();
        repeat (N_LOCK - 1) line(W_GATE, W_GATE);
        chk("R8 not yet locked", obs[4], 1'b0);
        line(W_GATE, W_GATE);
        chk("R8 locked", obs[4], 1'b1);

        // fine sweep, a good line before each quarter keeps lock
        line(W_GATE, W_GATE); sweep(0, 0, 1);
        line(W_GATE, W_GATE); sweep(1, 0, 1);
        line(W_GATE, W_GATE); sweep(0, 1, 1);
        line(W_GATE, W_GATE); sweep(1, 1, 1);

        // R9: loss after N_LOSS empty windows
        line(W_GATE, W_GATE);
        code = 8'd100;
        repeat (N_LOSS * WIN - 10) @(negedge clk);
        chk("R9 still fine", obs, 5'b10000);
        repeat (20) @(negedge clk);
        chk("R9 back to coarse", obs, 5'b00000);

        // R10: reset from fine mode
        repeat (N_LOCK) line(W_GATE, W_GATE);
        chk("R8 relock", obs[4], 1'b1);
        do_reset();
        chk("R10 coarse after reset", obs, 5'b00000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule